// File: doc/BRIEF.md
# Highway and Farm-Road Signal Controller

This block runs the signals at a crossing where a busy highway meets a lightly used farm road. The highway holds green by default. The farm road gets a green phase only when its car sensor reports a waiting vehicle and the highway has already had a full green interval. Every green phase ends with a yellow phase before the other road is released.

The block has two cooperating parts. A four-state sequencer decides the colours. A separate interval counter measures how long the current state has lasted and raises two flags: one for the short (yellow) duration and one for the long (green) duration. Whenever the sequencer is about to change state, it pulses a restart line that clears the counter. Because of this split, the durations are set by parameters measured in clock cycles, and the sequencer itself never depends on the clock period.

Top module: `tlc_xing_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the highway shows green, the farm road shows red, and both `short_done` and `long_done` are 0.
- R2: In highway-green, the state is held unless `car_waiting` and `long_done` are both 1.
- R3: In highway-green, when `car_waiting` and `long_done` are both 1, `restart` is 1 in that cycle and the next cycle is highway-yellow (highway yellow, farm red).
- R4: In highway-yellow, the state is held while `short_done` is 0 and moves to farm-green (farm green, highway red) after a cycle with `short_done` at 1. The sensor has no effect in this state.
- R5: In farm-green, the state is held while `car_waiting` is 1 and `long_done` is 0. It moves to farm-yellow (farm yellow, highway red) after a cycle with `car_waiting` at 0 or `long_done` at 1.
- R6: In farm-yellow, the state is held while `short_done` is 0 and moves to highway-green after a cycle with `short_done` at 1. The sensor has no effect in this state.
- R7: `restart` is 1 in exactly those cycles after which the state changes, and 0 in every cycle where the state is held.
- R8: The counter clears on each restart. `short_done` rises in the SHORT_TICKS-th cycle after the restart edge and `long_done` rises in the LONG_TICKS-th cycle. Each flag then stays at 1 until the next restart, and `long_done` at 1 implies `short_done` at 1.
- R9: In every cycle, at least one road shows red, and the two roads are never both non-red.
- R10: The colour codes are red=2'b00, yellow=2'b01 and green=2'b10. The code 2'b11 never appears on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_waiting | input | 1 | Farm-road sensor: a vehicle is waiting |
| hwy_light | output | 2 | Highway colour code |
| farm_light | output | 2 | Farm-road colour code |
| restart | output | 1 | Pulse that clears the interval counter on each state change |
| short_done | output | 1 | Yellow duration has elapsed since the last restart |
| long_done | output | 1 | Green duration has elapsed since the last restart |

## Verification
Every one of the four states has its own distinct pair of colour codes. A wrong state register therefore shows on `hwy_light` and `farm_light` in the very cycle after the faulty edge. A missing or extra transition breaks the rule that `restart` is paired with a colour change one cycle later.

Counter faults show up differently. A counter that misses a clear or counts wrongly shows up as a flag rising in the wrong cycle, or as a phase that is one cycle too long or too short. The directed scenarios count every cycle of each phase, so an error of one cycle is visible.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

   typedef enum logic [1:0] {
      LAMP_RED   = 2'b00,
      LAMP_AMBER = 2'b01,
      LAMP_GREEN = 2'b10
   } lamp_e;

   typedef enum logic [1:0] {
      ST_HWY_GO    = 2'd0,
      ST_HWY_SLOW  = 2'd1,
      ST_FARM_GO   = 2'd2,
      ST_FARM_SLOW = 2'd3
   } phase_e;

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
   parameter int SHORT_TICKS = 3,
   parameter int LONG_TICKS  = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic short_done,
   output logic long_done
);
   localparam int CNT_W = $clog2(LONG_TICKS + 1);
   localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_TICKS);
   localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_TICKS);

   logic [CNT_W-1:0] ticks;

   // counts up from the restart edge and saturates at the long limit
   always_ff @(posedge clk) begin
      if (rst || restart) begin
         ticks <= '0;
      end else if (ticks != LONG_LIM) begin
         ticks <= ticks + 1'b1;
      end
   end

   always_comb begin
      short_done = (ticks >= SHORT_LIM);
      long_done  = (ticks >= LONG_LIM);
   end
endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
   import tlc_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       car_waiting,
   input  logic       short_done,
   input  logic       long_done,
   output logic       restart,
   output logic [1:0] hwy_light,
   output logic [1:0] farm_light
);
   phase_e cur;
   phase_e nxt;

   always_comb begin
      nxt = cur;
      unique case (cur)
         ST_HWY_GO:    if (car_waiting && long_done)   nxt = ST_HWY_SLOW;
         ST_HWY_SLOW:  if (short_done)                 nxt = ST_FARM_GO;
         ST_FARM_GO:   if (!car_waiting || long_done)  nxt = ST_FARM_SLOW;
         ST_FARM_SLOW: if (short_done)                 nxt = ST_HWY_GO;
         default:                                      nxt = ST_HWY_GO;
      endcase
   end

   assign restart = (nxt != cur);

   generate
      if (ONE_HOT) begin : g_onehot
         logic [3:0] hot;
         always_ff @(posedge clk) begin
            if (rst) hot <= 4'b0001;
            else     hot <= 4'b0001 << nxt;
         end
         always_comb begin
            unique case (1'b1)
               hot[1]:  cur = ST_HWY_SLOW;
               hot[2]:  cur = ST_FARM_GO;
               hot[3]:  cur = ST_FARM_SLOW;
               default: cur = ST_HWY_GO;
            endcase
         end
      end else begin : g_binary
         phase_e st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_HWY_GO;
            else     st_q <= nxt;
         end
         assign cur = st_q;
      end
   endgenerate

   always_comb begin
      hwy_light  = LAMP_RED;
      farm_light = LAMP_RED;
      unique case (cur)
         ST_HWY_GO:    hwy_light  = LAMP_GREEN;
         ST_HWY_SLOW:  hwy_light  = LAMP_AMBER;
         ST_FARM_GO:   farm_light = LAMP_GREEN;
         ST_FARM_SLOW: farm_light = LAMP_AMBER;
         default:      hwy_light  = LAMP_RED;
      endcase
   end
endmodule

// File: rtl/tlc_xing_ctrl.sv
module tlc_xing_ctrl #(
   parameter int SHORT_TICKS = 3,
   parameter int LONG_TICKS  = 8,
   parameter bit ONE_HOT     = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       car_waiting,
   output logic [1:0] hwy_light,
   output logic [1:0] farm_light,
   output logic       restart,
   output logic       short_done,
   output logic       long_done
);
   generate
      if (SHORT_TICKS < 1) begin : g_bad_short
         $error("SHORT_TICKS must be at least 1");
      end
      if (LONG_TICKS <= SHORT_TICKS) begin : g_bad_long
         $error("LONG_TICKS must exceed SHORT_TICKS");
      end
   endgenerate

   tlc_interval_timer #(
      .SHORT_TICKS (SHORT_TICKS),
      .LONG_TICKS  (LONG_TICKS)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .restart    (restart),
      .short_done (short_done),
      .long_done  (long_done)
   );

   tlc_sequencer #(
      .ONE_HOT (ONE_HOT)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .car_waiting (car_waiting),
      .short_done  (short_done),
      .long_done   (long_done),
      .restart     (restart),
      .hwy_light   (hwy_light),
      .farm_light  (farm_light)
   );
endmodule

// File: rtl/tlc_xing_checker.sv
module tlc_xing_checker (
   input logic       clk,
   input logic       rst,
   input logic       car_waiting,
   input logic [1:0] hwy_light,
   input logic [1:0] farm_light,
   input logic       restart,
   input logic       short_done,
   input logic       long_done
);
   a_r9_one_red: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b00) || (farm_light == 2'b00));

   a_r10_no_code11: assert property (@(posedge clk) disable iff (rst)
      (hwy_light != 2'b11) && (farm_light != 2'b11));

   a_r7_restart_moves: assert property (@(posedge clk) disable iff (rst)
      restart |=> !$stable({hwy_light, farm_light}));

   a_r7_hold_steady: assert property (@(posedge clk) disable iff (rst)
      !restart |=> $stable({hwy_light, farm_light}));

   a_r8_flags_clear: assert property (@(posedge clk) disable iff (rst)
      restart |=> (!short_done && !long_done));

   a_r8_long_implies_short: assert property (@(posedge clk) disable iff (rst)
      long_done |-> short_done);

   a_r8_short_sticky: assert property (@(posedge clk) disable iff (rst)
      (short_done && !restart) |=> short_done);

   a_r8_long_sticky: assert property (@(posedge clk) disable iff (rst)
      (long_done && !restart) |=> long_done);

   a_r2_hwy_hold: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b10 && !(car_waiting && long_done)) |=> hwy_light == 2'b10);

   a_r3_hwy_leave: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b10 && car_waiting && long_done) |=> hwy_light == 2'b01);

   a_r4_to_farm: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b01 && short_done) |=> farm_light == 2'b10);

   a_r5_farm_leave: assert property (@(posedge clk) disable iff (rst)
      (farm_light == 2'b10 && (!car_waiting || long_done)) |=> farm_light == 2'b01);

   a_r6_to_hwy: assert property (@(posedge clk) disable iff (rst)
      (farm_light == 2'b01 && short_done) |=> hwy_light == 2'b10);
endmodule

bind tlc_xing_ctrl tlc_xing_checker u_xing_chk (
   .clk         (clk),
   .rst         (rst),
   .car_waiting (car_waiting),
   .hwy_light   (hwy_light),
   .farm_light  (farm_light),
   .restart     (restart),
   .short_done  (short_done),
   .long_done   (long_done)
);

// File: tb/tlc_xing_ctrl_bench.sv
`timescale 1ns/1ps
module tlc_xing_ctrl_bench;
   localparam int SHORT = 3;
   localparam int LONG  = 8;
   localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       car_waiting = 1'b0;
   logic [1:0] hwy_light, farm_light;
   logic       restart, short_done, long_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tlc_xing_ctrl #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u_tlc_xing_ctrl (
      .clk         (clk),
      .rst         (rst),
      .car_waiting (car_waiting),
      .hwy_light   (hwy_light),
      .farm_light  (farm_light),
      .restart     (restart),
      .short_done  (short_done),
      .long_done   (long_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic lights(input string req, input logic [1:0] h, input logic [1:0] f);
      chk({req, " hwy"}, hwy_light, h);
      chk({req, " farm"}, farm_light, f);
   endtask

   // one rising edge, then sampled at the falling edge; R9/R10 checked each cycle
   task automatic step();
      @(negedge clk);
      chk("R9 one red", int'(hwy_light == RED || farm_light == RED), 1);
      chk("R10 no 11", int'(hwy_light != 2'b11 && farm_light != 2'b11), 1);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic go_farm_green();
      do_reset();
      car_waiting = 1'b1;
      repeat (LONG + 1) step();
      repeat (SHORT + 1) step();
   endtask

   task automatic t_reset();
      rst = 1'b1;
      @(negedge clk);
      lights("R1 in reset", GRN, RED);
      rst = 1'b0;
      lights("R1 after reset", GRN, RED);
      chk("R1 short", short_done, 0);
      chk("R1 long", long_done, 0);
   endtask

   task automatic t_hwy_idle();
      do_reset();
      car_waiting = 1'b0;
      for (int k = 1; k <= LONG + 6; k++) begin
         step();
         chk("R2 hold", int'(hwy_light == GRN && farm_light == RED), 1);
         chk("R7 no restart", restart, 0);
         chk("R8 short flag", short_done, int'(k >= SHORT));
         chk("R8 long flag", long_done, int'(k >= LONG));
      end
   endtask

   task automatic t_full_cycle();
      do_reset();
      car_waiting = 1'b1;
      for (int k = 0; k <= LONG; k++) begin
         if (k > 0) step();
         lights("R2 waiting", GRN, RED);
         chk("R3 restart", restart, int'(k == LONG));
      end
      step();
      lights("R3 to yellow", YEL, RED);
      chk("R8 cleared short", short_done, 0);
      car_waiting = 1'b0;  // sensor ignored in yellow
      for (int k = 0; k <= SHORT; k++) begin
         if (k > 0) step();
         lights("R4 hold", YEL, RED);
         chk("R7 restart hy", restart, int'(k == SHORT));
      end
      step();
      lights("R4 to farm", RED, GRN);
      chk("R8 cleared long", long_done, 0);
   endtask

   task automatic t_farm_timeout();
      go_farm_green();
      lights("R5 entry", RED, GRN);
      for (int k = 0; k <= LONG; k++) begin
         if (k > 0) step();
         lights("R5 hold", RED, GRN);
         chk("R5 restart", restart, int'(k == LONG));
      end
      step();
      lights("R5 to yellow", RED, YEL);
      for (int k = 0; k <= SHORT; k++) begin
         if (k > 0) step();
         car_waiting = k[0];  // sensor ignored in farm yellow
         lights("R6 hold", RED, YEL);
         chk("R6 restart", restart, int'(k == SHORT));
      end
      step();
      lights("R6 to hwy", GRN, RED);
      chk("R8 cleared", short_done, 0);
   endtask

   task automatic t_farm_empty();
      go_farm_green();
      repeat (2) step();
      lights("R5 held", RED, GRN);
      car_waiting = 1'b0;
      #0.5;
      chk("R5 restart on empty", restart, 1);
      step();
      lights("R5 early exit", RED, YEL);
   endtask

   task automatic t_late_car();
      do_reset();
      car_waiting = 1'b0;
      repeat (LONG + 3) step();
      lights("R2 idle", GRN, RED);
      chk("R8 long held", long_done, 1);
      car_waiting = 1'b1;
      #0.5;
      chk("R3 late car restart", restart, 1);
      step();
      lights("R3 late car", YEL, RED);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_hwy_idle();
      t_full_cycle();
      t_farm_timeout();
      t_farm_empty();
      t_late_car();
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule